// File: doc/BRIEF.md
# Micro-Rotation CORDIC Unit

This unit turns an x/y pair of signed fixed-point values through one small, fixed angle picked by a 5-bit angle index. It does not iterate towards an arbitrary angle the way a full CORDIC does. Each index maps to a short, fixed recipe of shift-add steps that approximates an orthonormal rotation, so the length of the vector stays the same without a separate gain-correction pass. A direction input picks the sense of the turn. The unit suits iterative matrix methods, where each processing element only needs to nudge a pair of values by a predefined angle per sweep.

Each index falls into one of four recipe classes, and the classes differ in cost:

- **Tiny angles (indices 16 to 31):** one cross shift-add.
- **Small angles (8 to 15):** a cross step followed by one self-scaling step.
- **Medium angles (5 to 7):** one cross step and two self-scaling steps.
- **Large angles (1 to 4):** two identical cross steps followed by two to four self-scaling steps. This is the worst case, at six cycles for index 1.

Index 0 is the null angle. All classes run through one shared datapath. The datapath has two adders and two shifters, and a small set of multiplexers chooses between the cross operation and the self-scaling operation. With the repeat input set, the cheaper classes run their recipe several times back to back, so every operation uses about the same six-cycle budget.

Top module: `mrot_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done` is low and `xOut`/`yOut` read zero.
- R2: For index k in 16..31 the unit applies one cross step, x' = x - s*(y>>>k) and y' = y + s*(x>>>k), computed together from the old values, and completes in 1 cycle. Here `>>>` is a floor arithmetic shift.
- R3: For index k in 8..15 the unit applies the cross step by k and then a self step v' = v - (v>>>(2k+1)) on both values, completing in 2 cycles.
- R4: For index k in 5..7 the unit applies the cross step by k, then v' = v - (v>>>(2k+1)), then v' = v + (v>>>(4k+1)), completing in 3 cycles.
- R5: For index k in 1..4 the unit applies the cross step by k twice, then v - (v>>>2k), then v + (v>>>4k), v + (v>>>8k) and v + (v>>>16k), in that order. The number of steps is 6 for k=1, 5 for k=2 and 4 for k=3 and k=4, so the self steps are cut off after the first 2, 3 or 4.
- R6: Index 0 returns the inputs unchanged after 1 cycle.
- R7: `dir`=0 gives s=+1 (counter-clockwise) and `dir`=1 gives s=-1.
- R8: With `repeatEn` set, the whole recipe runs 6 times for indices 16..31, 3 times for indices 8..15 and 2 times for indices 5..7, and once otherwise. No operation is busy for more than 6 cycles.
- R9: Latency is counted in cycles after the edge that accepts `start`. `done` is a single-cycle pulse that rises together with the new `xOut`/`yOut`, and the outputs hold until the next completion.
- R10: A `start` seen while an operation is in progress is ignored, including at the edge on which that operation finishes. It causes neither a second result nor a second `done`.
- R11: For inputs up to 2^28 in magnitude, the output vector length matches the input length within 1e-6 relative plus 64 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| idx | input | 5 | Angle index, 0..31 |
| dir | input | 1 | Rotation sense: 0 counter-clockwise, 1 clockwise |
| repeatEn | input | 1 | Repeat cheap recipes to fill the cycle budget |
| xIn | input | W | Signed x operand |
| yIn | input | W | Signed y operand |
| xOut | output | W | Signed rotated x, registered |
| yOut | output | W | Signed rotated y, registered |
| done | output | 1 | One-cycle pulse marking new outputs |

## Verification
The hardest case to reach from the ports is a `start` that arrives while the unit is busy, and above all one that lands on the very edge where the six-cycle index-1 recipe finishes. At that edge the sequencer is dropping its busy state and could wrongly accept a new operation. The stimulus launches index 1 and then keeps `start` high with different operands on every following edge, up to and including the finishing one. It then checks that the first result is delivered unchanged and that no second `done` follows. A full sweep over every index, in both directions and with repeat on and off, compares bit-exact results and latencies against a model built from the step recipes. The same sweep checks the length of each output vector.

// File: rtl/mrot_pkg.sv
package mrot_pkg;

  localparam int IDX_W  = 5;   // angle index width, 32 selectable angles
  localparam int SH_W   = 5;   // shift amount width, shifts up to 31
  localparam int STEP_W = 3;   // step/repeat counter width
  localparam int BUDGET = 6;   // worst-case cycles of one operation

  // class boundaries on the angle index
  localparam int TINY_MIN  = 16;
  localparam int SMALL_MIN = 8;
  localparam int MED_MIN   = 5;

  // repeat counts that fill the cycle budget
  localparam int REP_TINY  = BUDGET / 1;
  localparam int REP_SMALL = BUDGET / 2;
  localparam int REP_MED   = BUDGET / 3;

  typedef enum logic [1:0] {
    OP_PASS   = 2'd0,
    OP_ROT    = 2'd1,
    OP_SCLSUB = 2'd2,
    OP_SCLADD = 2'd3
  } opE;

  typedef struct packed {
    logic            load;
    logic            step;
    logic            capture;
    logic            neg;
    opE              op;
    logic [SH_W-1:0] shamt;
  } dpCtrlT;

endpackage

// File: rtl/mrot_rom.sv
module mrot_rom
  import mrot_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [STEP_W-1:0] stepNum,
  input  logic              repeatOn,
  output opE                op,
  output logic [SH_W-1:0]   shamt,
  output logic [STEP_W-1:0] nSteps,
  output logic [STEP_W-1:0] nReps
);

  int kVal;
  int shVal;
  int stepsVal;
  int repsVal;

  always_comb begin
    kVal     = int'(idx);
    op       = OP_PASS;
    shVal    = 0;
    stepsVal = 1;
    repsVal  = 1;
    if (kVal >= TINY_MIN) begin
      stepsVal = 1;
      op       = OP_ROT;
      shVal    = kVal;
      repsVal  = repeatOn ? REP_TINY : 1;
    end else if (kVal >= SMALL_MIN) begin
      stepsVal = 2;
      repsVal  = repeatOn ? REP_SMALL : 1;
      if (stepNum == 3'd0) begin
        op    = OP_ROT;
        shVal = kVal;
      end else begin
        op    = OP_SCLSUB;
        shVal = 2 * kVal + 1;
      end
    end else if (kVal >= MED_MIN) begin
      stepsVal = 3;
      repsVal  = repeatOn ? REP_MED : 1;
      case (stepNum)
        3'd0: begin op = OP_ROT;    shVal = kVal;         end
        3'd1: begin op = OP_SCLSUB; shVal = 2 * kVal + 1; end
        default: begin op = OP_SCLADD; shVal = 4 * kVal + 1; end
      endcase
    end else if (kVal >= 1) begin
      repsVal  = 1;
      if (kVal == 1)      stepsVal = 6;
      else if (kVal == 2) stepsVal = 5;
      else                stepsVal = 4;
      case (stepNum)
        3'd0, 3'd1: begin op = OP_ROT;    shVal = kVal;      end
        3'd2:       begin op = OP_SCLSUB; shVal = 2 * kVal;  end
        3'd3:       begin op = OP_SCLADD; shVal = 4 * kVal;  end
        3'd4:       begin op = OP_SCLADD; shVal = 8 * kVal;  end
        default:    begin op = OP_SCLADD; shVal = 16 * kVal; end
      endcase
    end
    shamt  = shVal[SH_W-1:0];
    nSteps = stepsVal[STEP_W-1:0];
    nReps  = repsVal[STEP_W-1:0];
  end

endmodule

// File: rtl/mrot_ctrl.sv
module mrot_ctrl
  import mrot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] idx,
  input  logic             dir,
  input  logic             repeatEn,
  output dpCtrlT           ctl
);

  logic              busy;
  logic [STEP_W-1:0] stepCnt;
  logic [STEP_W-1:0] repCnt;
  logic [IDX_W-1:0]  idxR;
  logic              negR;
  logic              repR;

  opE                romOp;
  logic [SH_W-1:0]   romSh;
  logic [STEP_W-1:0] nSteps;
  logic [STEP_W-1:0] nReps;
  logic              lastStep;
  logic              lastRep;

  mrot_rom u_rom (
    .idx      (idxR),
    .stepNum  (stepCnt),
    .repeatOn (repR),
    .op       (romOp),
    .shamt    (romSh),
    .nSteps   (nSteps),
    .nReps    (nReps)
  );

  assign lastStep = (stepCnt == nSteps - STEP_W'(1));
  assign lastRep  = (repCnt == nReps - STEP_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      repCnt  <= '0;
      idxR    <= '0;
      negR    <= 1'b0;
      repR    <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        idxR    <= idx;
        negR    <= dir;
        repR    <= repeatEn;
        stepCnt <= '0;
        repCnt  <= '0;
      end
    end else if (lastStep) begin
      stepCnt <= '0;
      if (lastRep) busy   <= 1'b0;
      else         repCnt <= repCnt + STEP_W'(1);
    end else begin
      stepCnt <= stepCnt + STEP_W'(1);
    end
  end

  always_comb begin
    ctl.load    = start && !busy;
    ctl.step    = busy;
    ctl.capture = busy && lastStep && lastRep;
    ctl.neg     = negR;
    ctl.op      = romOp;
    ctl.shamt   = romSh;
  end

  // cycle budget watch: counts consecutive busy cycles
  logic [3:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busyLen <= '0;
    else if (!busy) busyLen <= '0;
    else            busyLen <= busyLen + 4'd1;
  end

  // R8
  budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyLen < 4'(BUDGET)));

  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(idxR) && $stable(negR) && $stable(repR)));

  // R5
  step_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepCnt < nSteps));

endmodule

// File: rtl/mrot_dp.sv
module mrot_dp
  import mrot_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrlT              ctl,
  input  logic signed [W-1:0] xIn,
  input  logic signed [W-1:0] yIn,
  output logic signed [W-1:0] xOut,
  output logic signed [W-1:0] yOut,
  output logic                done
);

  logic signed [W-1:0] xR, yR;
  logic signed [W-1:0] srcX, srcY;
  logic signed [W-1:0] shX, shY;
  logic signed [W-1:0] xNext, yNext;
  logic                xSub, ySub;

  // operand steering: cross for rotation, self for scaling
  always_comb begin
    srcX = (ctl.op == OP_ROT) ? yR : xR;
    srcY = (ctl.op == OP_ROT) ? xR : yR;
    shX  = srcX >>> ctl.shamt;
    shY  = srcY >>> ctl.shamt;
    if (ctl.op == OP_PASS) begin
      shX = '0;
      shY = '0;
    end
    xSub = (ctl.op == OP_ROT) ? !ctl.neg : (ctl.op == OP_SCLSUB);
    ySub = (ctl.op == OP_ROT) ?  ctl.neg : (ctl.op == OP_SCLSUB);
  end

  // the two shared adders
  assign xNext = xSub ? (xR - shX) : (xR + shX);
  assign yNext = ySub ? (yR - shY) : (yR + shY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xR   <= '0;
      yR   <= '0;
      xOut <= '0;
      yOut <= '0;
      done <= 1'b0;
    end else begin
      if (ctl.load) begin
        xR <= xIn;
        yR <= yIn;
      end else if (ctl.step) begin
        xR <= xNext;
        yR <= yNext;
      end
      if (ctl.capture) begin
        xOut <= xNext;
        yOut <= yNext;
      end
      done <= ctl.capture;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(xOut) && $stable(yOut)));

endmodule

// File: rtl/mrot_unit.sv
module mrot_unit
  import mrot_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [IDX_W-1:0]    idx,
  input  logic                dir,
  input  logic                repeatEn,
  input  logic signed [W-1:0] xIn,
  input  logic signed [W-1:0] yIn,
  output logic signed [W-1:0] xOut,
  output logic signed [W-1:0] yOut,
  output logic                done
);

  dpCtrlT ctl;

  mrot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .idx      (idx),
    .dir      (dir),
    .repeatEn (repeatEn),
    .ctl      (ctl)
  );

  mrot_dp #(.W(W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .xIn  (xIn),
    .yIn  (yIn),
    .xOut (xOut),
    .yOut (yOut),
    .done (done)
  );

endmodule

// File: tb/mrot_unit_tb.sv
module mrot_unit_tb;

  localparam int W = 32;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic [4:0]          idxIn = '0;
  logic                dirIn = 1'b0;
  logic                repIn = 1'b0;
  logic signed [W-1:0] xIn = '0;
  logic signed [W-1:0] yIn = '0;
  logic signed [W-1:0] xOut, yOut;
  logic                done;

  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;   // 50 MHz

  mrot_unit #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .idx(idxIn), .dir(dirIn),
    .repeatEn(repIn), .xIn(xIn), .yIn(yIn), .xOut(xOut), .yOut(yOut), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected result built from the step recipes of R2..R8
  function automatic void model(input int k, input bit neg, input bit rep,
                                input longint xi, input longint yi,
                                output longint xo, output longint yo, output int cyc);
    int nS, nR;
    int opA[6];
    int shA[6];
    longint x, y, tx, ty, s;
    for (int i = 0; i < 6; i++) begin opA[i] = 0; shA[i] = 0; end
    nS = 1; nR = 1;
    if (k >= 16) begin
      opA[0] = 1; shA[0] = k; nR = rep ? 6 : 1;
    end else if (k >= 8) begin
      nS = 2; opA[0] = 1; shA[0] = k; opA[1] = 2; shA[1] = 2*k+1; nR = rep ? 3 : 1;
    end else if (k >= 5) begin
      nS = 3; opA[0] = 1; shA[0] = k; opA[1] = 2; shA[1] = 2*k+1;
      opA[2] = 3; shA[2] = 4*k+1; nR = rep ? 2 : 1;
    end else if (k >= 1) begin
      opA[0] = 1; shA[0] = k; opA[1] = 1; shA[1] = k;
      opA[2] = 2; shA[2] = 2*k; opA[3] = 3; shA[3] = 4*k;
      opA[4] = 3; shA[4] = 8*k; opA[5] = 3; shA[5] = 16*k;
      nS = (k == 1) ? 6 : ((k == 2) ? 5 : 4);
    end
    s = neg ? -1 : 1;
    x = xi; y = yi;
    for (int r = 0; r < nR; r++) begin
      for (int i = 0; i < nS; i++) begin
        case (opA[i])
          1: begin tx = y >>> shA[i]; ty = x >>> shA[i]; x = x - s*tx; y = y + s*ty; end
          2: begin x = x - (x >>> shA[i]); y = y - (y >>> shA[i]); end
          3: begin x = x + (x >>> shA[i]); y = y + (y >>> shA[i]); end
          default: ;
        endcase
      end
    end
    xo = x; yo = y; cyc = nS * nR;
  endfunction

  task automatic runOp(input int k, input bit neg, input bit rep,
                       input longint xv, input longint yv, input string tag,
                       output longint xr, output longint yr);
    longint ex, ey;
    int ecyc, lat;
    real nIn, nOut, tol;
    longint hx, hy;
    model(k, neg, rep, xv, yv, ex, ey, ecyc);
    @(negedge clk);
    start = 1'b1; idxIn = k[4:0]; dirIn = neg; repIn = rep;
    xIn = xv[W-1:0]; yIn = yv[W-1:0];
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == ecyc, {tag, " latency"}, lat, ecyc);
    check(longint'(xOut) == ex, {tag, " x"}, longint'(xOut), ex);
    check(longint'(yOut) == ey, {tag, " y"}, longint'(yOut), ey);
    nIn  = $sqrt(real'(xv)*real'(xv) + real'(yv)*real'(yv));
    nOut = $sqrt(real'(xOut)*real'(xOut) + real'(yOut)*real'(yOut));
    tol  = 1.0e-6 * nIn + 64.0;
    // R11 length preserved
    check((nOut - nIn) <= tol && (nIn - nOut) <= tol, {tag, " R11 norm"},
          longint'(nOut), longint'(nIn));
    hx = longint'(xOut); hy = longint'(yOut);
    @(negedge clk);
    // R9 single-cycle pulse, outputs held
    check(!done, {tag, " R9 done pulse"}, longint'(done), 0);
    check(longint'(xOut) == hx && longint'(yOut) == hy, {tag, " R9 hold"},
          longint'(xOut), hx);
    xr = longint'(xOut); yr = longint'(yOut);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && xOut == 0 && yOut == 0, "R1 in reset", longint'(xOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!done, "R1 done after reset", longint'(done), 0);
    check(xOut == 0 && yOut == 0, "R1 outputs after reset", longint'(yOut), 0);
  endtask

  task automatic t_tiny();
    longint xr, yr;
    runOp(20, 1'b0, 1'b0, 64'sd134217728, 64'sd67108864, "R2 idx20", xr, yr);
    check(xr == 64'sd134217664, "R2 idx20 literal x", xr, 134217664);
    check(yr == 64'sd67108992, "R2 idx20 literal y", yr, 67108992);
    runOp(31, 1'b1, 1'b0, -64'sd99999999, 64'sd12345678, "R2 idx31", xr, yr);
  endtask

  task automatic t_small();
    longint xr, yr;
    runOp(8,  1'b0, 1'b0, 64'sd123456789, -64'sd98765432, "R3 idx8", xr, yr);
    runOp(15, 1'b1, 1'b0, -64'sd200000000, -64'sd1000, "R3 idx15", xr, yr);
  endtask

  task automatic t_medium();
    longint xr, yr;
    runOp(5, 1'b0, 1'b0, 64'sd150000000, 64'sd150000000, "R4 idx5", xr, yr);
    runOp(7, 1'b1, 1'b0, -64'sd77777777, 64'sd222222222, "R4 idx7", xr, yr);
  endtask

  task automatic t_large();
    longint xr, yr;
    runOp(1, 1'b0, 1'b0, 64'sd200000000, 64'sd100000000, "R5 idx1", xr, yr);
    runOp(2, 1'b1, 1'b0, -64'sd180000000, 64'sd90000000, "R5 idx2", xr, yr);
    runOp(4, 1'b0, 1'b0, 64'sd3, -64'sd260000000, "R5 idx4", xr, yr);
  endtask

  task automatic t_zero();
    longint xr, yr;
    runOp(0, 1'b1, 1'b1, -64'sd5555555, 64'sd7777777, "R6 idx0", xr, yr);
    check(xr == -64'sd5555555 && yr == 64'sd7777777, "R6 unchanged", xr, -5555555);
  endtask

  task automatic t_direction();
    longint xr, yr;
    runOp(16, 1'b0, 1'b0, 64'sd134217728, 64'sd0, "R7 ccw", xr, yr);
    check(yr == 64'sd2048, "R7 ccw y sign", yr, 2048);
    runOp(16, 1'b1, 1'b0, 64'sd134217728, 64'sd0, "R7 cw", xr, yr);
    check(yr == -64'sd2048, "R7 cw y sign", yr, -2048);
  endtask

  task automatic t_repeat();
    longint xr, yr;
    runOp(8,  1'b0, 1'b1, 64'sd100000000, 64'sd50000000, "R8 idx8 x3", xr, yr);
    runOp(20, 1'b1, 1'b1, 64'sd100000000, 64'sd50000000, "R8 idx20 x6", xr, yr);
    runOp(6,  1'b0, 1'b1, -64'sd100000000, 64'sd50000000, "R8 idx6 x2", xr, yr);
    runOp(1,  1'b1, 1'b1, 64'sd100000000, 64'sd50000000, "R8 idx1 x1", xr, yr);
  endtask

  task automatic t_busyStart();
    longint ex, ey, hx, hy;
    int ecyc;
    bit extra;
    model(1, 1'b0, 1'b0, 64'sd200000000, -64'sd60000000, ex, ey, ecyc);
    @(negedge clk);
    start = 1'b1; idxIn = 5'd1; dirIn = 1'b0; repIn = 1'b0;
    xIn = 32'sd200000000; yIn = -32'sd60000000;
    @(negedge clk);
    idxIn = 5'd20; dirIn = 1'b1; xIn = 32'sd1; yIn = 32'sd2;
    repeat (5) @(negedge clk);   // start held high through the finishing edge
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R10 first op done", longint'(done), 1);
    check(longint'(xOut) == ex, "R10 first result x", longint'(xOut), ex);
    check(longint'(yOut) == ey, "R10 first result y", longint'(yOut), ey);
    hx = longint'(xOut); hy = longint'(yOut);
    extra = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    check(!extra, "R10 no second done", longint'(extra), 0);
    check(longint'(xOut) == hx && longint'(yOut) == hy, "R10 outputs kept",
          longint'(xOut), hx);
  endtask

  task automatic t_sweep();
    longint xr, yr;
    for (int k = 0; k < 32; k++) begin
      for (int d = 0; d < 2; d++) begin
        for (int r = 0; r < 2; r++) begin
          runOp(k, d[0], r[0], 64'sd170000000 - longint'(k) * 64'sd3000001,
                -64'sd90000000 + longint'(k) * 64'sd7000003, "R11 sweep", xr, yr);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_tiny();
    t_small();
    t_medium();
    t_large();
    t_zero();
    t_direction();
    t_repeat();
    t_busyStart();
    t_sweep();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule